// File: doc/BRIEF.md
# Tenure-Based Two-Agent Bus Arbiter

This block decides which of two agents, an external bus master or the host bridge, owns a shared graphics port. Once an agent holds the grant, it keeps the port for a guaranteed minimum tenure. The tenure is set by a programmable multi-transaction timer. While the owner's traffic is low-priority data transfer, a second timer governs the tenure instead. That second timer may span several back-to-back low-priority transactions of the same direction. A high-priority request from the waiting side overrides it. Both timers count in units of eight clocks, and a zero setting turns the timer off, which leaves plain per-transaction alternation.

Grant changes happen only at transaction boundaries, which the bus logic marks with `xfer_done`. The one exception is an owner that withdraws its request: that owner gives the port up on the next clock. The two 8-bit timer registers sit behind a small write/read port. Bus signalling, data paths and queues belong to the surrounding logic.

Top module: `tenure_arb`

## Requirements
- R1: After reset, `gnt` is 00 and both timer registers read 00h.
- R2: `reg_sel`=0 addresses the multi-transaction timer and `reg_sel`=1 addresses the low-priority timer. A write stores bits 7:3. Bits 2:0 always read as zero. `reg_rdata` shows the register selected by `reg_sel` in the same cycle.
- R3: `gnt` is one-hot or zero, with bit 0 for the host bridge and bit 1 for the bus master. When the port is idle, a lone requester is granted on the next edge. For simultaneous requests, the host wins the first tie after reset, and later ties alternate.
- R4: While the owner keeps requesting, `gnt` can change only on an edge where `xfer_done` is 1.
- R5: If the owner drops its request, its grant is removed on the next edge. The grant passes to the other agent if that agent is requesting, and otherwise `gnt` becomes 00.
- R6: Outside the low-priority state (`lp_req`=0), the slice S equals the multi-transaction register value, which is a multiple of 8. With `xfer_done` held at 1 and the other agent requesting, the grant moves on the S-th edge after the granting edge. For 18h, that is the 24th edge.
- R7: A timer value of 00h gives no protection. At every boundary where the other agent requests, the grant alternates.
- R8: While `lp_req`=1, the low-priority timer sets the tenure and the multi-transaction timer is ignored. The low-priority timer reloads when ownership changes and when `lp_wr` (1 = write, 0 = read) differs from the direction of the previous low-priority cycle.
- R9: When the low-priority tenure has expired and no other request is pending, the owner keeps the grant. The grant moves at the first boundary after the other agent requests.
- R10: In the low-priority state, `hp_req`=1 together with a request from the other agent moves the grant at the next boundary, even though the low-priority tenure has not expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 multi-transaction, 1 low-priority |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| req_host | input | 1 | Host bridge requests the port |
| req_mst | input | 1 | External bus master requests the port |
| lp_req | input | 1 | Owner's traffic is in the low-priority data transfer state |
| hp_req | input | 1 | Waiting side has a high-priority request |
| lp_wr | input | 1 | Direction of the low-priority transfer, 1 = write |
| xfer_done | input | 1 | Current transaction ends this cycle |
| gnt | output | 2 | One-hot grant: bit 0 host bridge, bit 1 bus master |

## Verification
The bench times tenures to the exact edge. If the slice were off by one clock, the hand-over would show up one sample early or late. If the tie pointer were mishandled, the second simultaneous request would go to the host again. The bench flips the transfer direction in the middle of a low-priority tenure, and a missing reload would hand the port over at the sixteenth edge instead of the twenty-fifth. It also checks the override case, where an unexpired low-priority tenure must still yield to a high-priority request. A design that let the override or an expired timer act without a boundary would drop the grant while `xfer_done` is low.

// File: rtl/tenure_arb.sv
module tenure_arb #(
  parameter int REG_W     = 8,
  parameter int GRAN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             req_host,
  input  logic             req_mst,
  input  logic             lp_req,
  input  logic             hp_req,
  input  logic             lp_wr,
  input  logic             xfer_done,
  output logic [1:0]       gnt
);
  localparam logic [REG_W-1:0] CNT_MASK = {{(REG_W-GRAN_LOG2){1'b1}}, {GRAN_LOG2{1'b0}}};
  localparam logic [REG_W-1:0] ONE      = {{(REG_W-1){1'b0}}, 1'b1};

  logic [REG_W-1:0] mtt_reg, lpt_reg, mtt_cnt, lpt_cnt;
  logic [1:0]       gnt_q, gnt_d;
  logic             tie_mst_q, tie_mst_d, last_wr_q;

  assign reg_rdata = reg_sel ? lpt_reg : mtt_reg;
  assign gnt       = gnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mtt_reg <= '0;
      lpt_reg <= '0;
    end else if (reg_wr) begin
      if (reg_sel) lpt_reg <= reg_wdata & CNT_MASK;
      else         mtt_reg <= reg_wdata & CNT_MASK;
    end
  end

  wire       own_req  = (gnt_q[0] & req_host) | (gnt_q[1] & req_mst);
  wire       oth_req  = (gnt_q[0] & req_mst)  | (gnt_q[1] & req_host);
  wire [1:0] oth_gnt  = {gnt_q[0], gnt_q[1]};
  wire       mtt_exp  = mtt_cnt <= ONE;
  wire       lpt_exp  = lpt_cnt <= ONE;
  wire       tenure_over = lp_req ? (lpt_exp | hp_req) : mtt_exp;
  wire       own_chg  = gnt_d != gnt_q;
  wire       type_chg = lp_req && (lp_wr != last_wr_q);

  always_comb begin
    gnt_d     = gnt_q;
    tie_mst_d = tie_mst_q;
    if (gnt_q == 2'b00) begin
      if (req_host && req_mst) begin
        gnt_d     = tie_mst_q ? 2'b10 : 2'b01;
        tie_mst_d = !tie_mst_q;
      end else if (req_host) begin
        gnt_d = 2'b01;
      end else if (req_mst) begin
        gnt_d = 2'b10;
      end
    end else if (!own_req) begin
      gnt_d = oth_req ? oth_gnt : 2'b00;
    end else if (xfer_done && oth_req && tenure_over) begin
      gnt_d = oth_gnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q     <= 2'b00;
      tie_mst_q <= 1'b0;
      mtt_cnt   <= '0;
      lpt_cnt   <= '0;
      last_wr_q <= 1'b0;
    end else begin
      gnt_q     <= gnt_d;
      tie_mst_q <= tie_mst_d;
      if (own_chg)              mtt_cnt <= mtt_reg;
      else if (mtt_cnt != '0)   mtt_cnt <= mtt_cnt - ONE;
      if (own_chg || type_chg)          lpt_cnt <= lpt_reg;
      else if (lp_req && lpt_cnt != '0) lpt_cnt <= lpt_cnt - ONE;
      if (lp_req) last_wr_q <= lp_wr;
    end
  end
endmodule

// File: rtl/tenure_arb_chk.sv
module tenure_arb_chk #(
  parameter int REG_W     = 8,
  parameter int GRAN_LOG2 = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             req_host,
  input logic             req_mst,
  input logic             xfer_done,
  input logic [1:0]       gnt
);
  localparam logic [REG_W-1:0] MASK = {{(REG_W-GRAN_LOG2){1'b1}}, {GRAN_LOG2{1'b0}}};
  wire holder_req = (gnt[0] & req_host) | (gnt[1] & req_mst);

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R3
  host_req_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gnt[0]) |-> $past(req_host));
  // R3
  mst_req_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gnt[1]) |-> $past(req_mst));
  // R4
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holder_req && !xfer_done) |=> $stable(gnt));
  // R5
  host_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt[0] && !req_host) |=> !gnt[0]);
  // R5
  mst_release_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt[1] && !req_mst) |=> !gnt[1]);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_sel != $past(reg_sel) || reg_rdata == ($past(reg_wdata) & MASK)));
endmodule

bind tenure_arb tenure_arb_chk #(.REG_W(REG_W), .GRAN_LOG2(GRAN_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .req_host(req_host), .req_mst(req_mst), .xfer_done(xfer_done),
  .gnt(gnt)
);

// File: tb/tenure_arb_tb.sv
module tenure_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic req_host = 1'b0, req_mst = 1'b0, lp_req = 1'b0, hp_req = 1'b0, lp_wr = 1'b0, xfer_done = 1'b0;
  logic [1:0] gnt;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  tenure_arb dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_host(req_host), .req_mst(req_mst), .lp_req(lp_req),
    .hp_req(hp_req), .lp_wr(lp_wr), .xfer_done(xfer_done), .gnt(gnt)
  );

  // {req_host, req_mst, lp_req, hp_req, lp_wr, xfer_done, expected gnt[1:0]}
  localparam logic [7:0] VEC [10] = '{
    8'b11000001, // R3 first tie to host
    8'b11000001, // R4 no boundary, hold
    8'b11000110, // R7 zero timer alternates
    8'b11000101, // R7
    8'b01000010, // R5 host drops, master takes over
    8'b01000110, // R7 lone owner keeps port
    8'b00000000, // R5 release to idle
    8'b11000010, // R3 second tie to master
    8'b00000000, // R5
    8'b10000001  // R3 lone requester
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic idle();
    req_host = 0; req_mst = 0; lp_req = 0; hp_req = 0; lp_wr = 0; xfer_done = 0;
    step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gnt", {6'b0, gnt}, 8'h00);
    reg_sel = 0; #1 chk("R1 mtt reg", reg_rdata, 8'h00);
    reg_sel = 1; #1 chk("R1 lpt reg", reg_rdata, 8'h00);
    reg_sel = 0;

    for (int i = 0; i < 10; i++) begin
      {req_host, req_mst, lp_req, hp_req, lp_wr, xfer_done} = VEC[i][7:2];
      step();
      chk($sformatf("table R3 R4 R5 R7 vec %0d", i), {6'b0, gnt}, {6'b0, VEC[i][1:0]});
    end
    idle();

    wr_reg(0, 8'h1F); reg_sel = 0; #1 chk("R2 mtt readback", reg_rdata, 8'h18);
    wr_reg(1, 8'h17); reg_sel = 1; #1 chk("R2 lpt readback", reg_rdata, 8'h10);
    reg_sel = 0; #1 chk("R2 select", reg_rdata, 8'h18);

    // R6: 24-clock slice
    req_host = 1; step();
    chk("R6 granted", {6'b0, gnt}, 8'h01);
    req_mst = 1; xfer_done = 1;
    ok = 1;
    for (int k = 1; k <= 23; k++) begin step(); if (gnt !== 2'b01) ok = 0; end
    chk("R6 held 23 edges", {7'b0, ok}, 8'h01);
    step();
    chk("R6 moved at 24th edge", {6'b0, gnt}, 8'h02);

    // R5: early drop
    req_mst = 0; step();
    chk("R5 drop to other", {6'b0, gnt}, 8'h01);
    req_host = 0; step();
    chk("R5 drop to idle", {6'b0, gnt}, 8'h00);
    idle();

    // R8: 16-clock low-priority tenure, direction change reloads
    req_host = 1; lp_req = 1; lp_wr = 0; xfer_done = 1; step();
    req_mst = 1;
    ok = 1;
    for (int k = 1; k <= 24; k++) begin
      step();
      if (gnt !== 2'b01) ok = 0;
      if (k == 8) lp_wr = 1;
    end
    chk("R8 held through reload", {7'b0, ok}, 8'h01);
    step();
    chk("R8 moved at 25th edge", {6'b0, gnt}, 8'h02);
    idle();

    // R9: expired, nobody waiting
    req_host = 1; lp_req = 1; xfer_done = 1; step();
    repeat (20) step();
    chk("R9 owner kept", {6'b0, gnt}, 8'h01);
    req_mst = 1; step();
    chk("R9 moved once pending", {6'b0, gnt}, 8'h02);
    idle();

    // R10: high-priority override, only at a boundary
    req_host = 1; lp_req = 1; step();
    req_mst = 1; hp_req = 1;
    repeat (3) step();
    chk("R4 override waits for boundary", {6'b0, gnt}, 8'h01);
    xfer_done = 1; step();
    chk("R10 override", {6'b0, gnt}, 8'h02);
    idle();

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule